// File: doc/BRIEF.md
# Memory error capture and interrupt unit

This unit sits beside an ECC memory controller and records what its ECC checker reports. The checker pulses a single-bit or multi-bit error indication together with the failing address, the 64-bit data word and the check bits. The unit keeps sticky detect flags and a single-bit event counter with a programmable threshold. It freezes a snapshot of the first failing access and raises a level interrupt according to per-type enables.

Software reaches every register through a plain word-indexed read/write port. The read data is combinational. A write takes effect at the clock edge where `reg_wr_i` is high.

A typical handler runs in four steps. It reads the detect register, reads the snapshot, and reads the counter if it needs it. It then clears the flags by writing ones, which re-arms the snapshot. Detection of either error type can be masked through a disable register that reads back all of its bits, so software can save it and restore it later.

Top module: `mem_err_report`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. Register indices on `reg_addr_i`: 0 detect, 1 interrupt enable, 2 disable, 3 single-bit control, 4 data bits 63:32, 5 data bits 31:0, 6 check bits, 7 address bits 31:0, 8 address bits above 31 (zero-extended). Any other index reads zero.
- R2: An unmasked multi-bit event sets detect bit 1 at the next clock edge.
- R3: Each unmasked single-bit event increments the counter, which reads in bits 7:0 of register 3. The threshold sits in bits 23:16 of register 3. When an event brings the count to or past a non-zero threshold, detect bit 0 is set and the count returns to zero.
- R4: With a threshold of 1, every single-bit event sets detect bit 0.
- R5: With a threshold of 0, single-bit events never set detect bit 0, and the counter stays at zero.
- R6: Writing register 0 clears each detect bit that is written with 1 and leaves the bits written with 0. An event that arrives in the same cycle as a clear wins, and the flag stays set.
- R7: On an unmasked event of either type, while no detect bit is set, registers 4 to 8 load the data, check and address inputs.
- R8: While any detect bit is set, registers 4 to 8 do not change.
- R9: When `narrow_bus_i` is high the captured check field keeps all 16 bits. When it is low, only bits 7:0 are kept and the upper bits read zero.
- R10: Register 2 reads back all 32 written bits. Bit 0 masks single-bit events and bit 1 masks multi-bit events. A masked event does not count, set a flag or capture.
- R11: `irq_o` is high when (detect bit 0 and enable bit 0) or (detect bit 1 and enable bit 1) is true. Register 1 reads back its two enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sbe_i | input | 1 | Single-bit error event, one cycle per event |
| mbe_i | input | 1 | Multi-bit error event, one cycle per event |
| err_addr_i | input | ADDR_W | Address of the failing access |
| err_data_i | input | 64 | Data word of the failing access |
| err_chk_i | input | 16 | Check bits of the failing access |
| narrow_bus_i | input | 1 | High selects 32-bit bus mode (16-bit check field) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- a multi-bit event sets its flag;
- a written one clears its flag;
- a masked multi-bit event, or a zero threshold, leaves the flags alone;
- the counter steps, returns to zero after a hit and stays at zero with a zero threshold;
- the snapshot holds whenever no load is requested;
- the interrupt holds until software writes.

Exact threshold counts are shown only by the bench scenarios, as are the same-cycle set-versus-clear race, check-field masking in both bus modes, the disable register readback and the snapshot values. In those scenarios a behavioural model is compared with every readable register after each clock.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;
  localparam int REG_AW  = 4;
  localparam int REG_DW  = 32;
  localparam int THR_W   = 8;
  localparam int THR_LSB = 16;
  localparam int FLAG_SB = 0;
  localparam int FLAG_MB = 1;

  typedef enum logic [REG_AW-1:0] {
    RG_DETECT   = 4'd0,
    RG_IRQ_EN   = 4'd1,
    RG_DISABLE  = 4'd2,
    RG_SB_CTRL  = 4'd3,
    RG_DATA_HI  = 4'd4,
    RG_DATA_LO  = 4'd5,
    RG_CHECK    = 4'd6,
    RG_ADDR_LO  = 4'd7,
    RG_ADDR_EXT = 4'd8
  } reg_idx_e;
endpackage

// File: rtl/err_sbe_counter.sv
module err_sbe_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sbe_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // >= so a threshold lowered below the running count still fires
  assign hit_o   = sbe_i && (thr_i != '0) && (cnt_inc >= {1'b0, thr_i});
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (thr_i == '0)      cnt_q <= '0;
    else if (hit_o)            cnt_q <= '0;
    else if (sbe_i)            cnt_q <= cnt_inc[CNT_W-1:0];
  end

  p_hit_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == '0);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_i && !hit_o && thr_i != '0) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_zero_thr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_i == '0) |=> cnt_q == '0);
endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 64,
  parameter int CHK_W   = 16,
  parameter int WIDE_CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              narrow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  chk_o
);
  localparam int PAD_W = CHK_W - WIDE_CW;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CHK_W-1:0]  chk_q;
  logic [CHK_W-1:0]  chk_sel;

  // 64-bit bus: only the low check byte is meaningful
  assign chk_sel = narrow_i ? chk_i : {{PAD_W{1'b0}}, chk_i[WIDE_CW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      chk_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
      chk_q  <= chk_sel;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign chk_o  = chk_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(addr_q) && $stable(data_q) && $stable(chk_q)));
  p_wide_chk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !narrow_i) |=> chk_q[CHK_W-1:WIDE_CW] == '0);
endmodule

// File: rtl/mem_err_report.sv
module mem_err_report
  import mem_err_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int CHK_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [CHK_W-1:0]  err_chk_i,
  input  logic              narrow_bus_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ADDR_W - 32;

  logic [1:0]        flags_q, irq_en_q, clr, set;
  logic [REG_DW-1:0] dis_q;
  logic [THR_W-1:0]  thr_q, cnt;
  logic              sb_ev, mb_ev, sb_hit, cap_load;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [CHK_W-1:0]  cap_chk;

  assign sb_ev    = sbe_i && !dis_q[FLAG_SB];
  assign mb_ev    = mbe_i && !dis_q[FLAG_MB];
  assign cap_load = (sb_ev || mb_ev) && (flags_q == '0);

  err_sbe_counter #(.CNT_W(THR_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sbe_i  (sb_ev),
    .thr_i  (thr_q),
    .cnt_o  (cnt),
    .hit_o  (sb_hit)
  );

  err_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (cap_load),
    .narrow_i (narrow_bus_i),
    .addr_i   (err_addr_i),
    .data_i   (err_data_i),
    .chk_i    (err_chk_i),
    .addr_o   (cap_addr),
    .data_o   (cap_data),
    .chk_o    (cap_chk)
  );

  assign clr = (reg_wr_i && reg_addr_i == RG_DETECT) ? reg_wdata_i[1:0] : 2'b00;
  assign set = {mb_ev, sb_hit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      irq_en_q <= '0;
      dis_q    <= '0;
      thr_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | set;  // new event beats a same-cycle clear
      if (reg_wr_i) begin
        case (reg_addr_i)
          RG_IRQ_EN:  irq_en_q <= reg_wdata_i[1:0];
          RG_DISABLE: dis_q    <= reg_wdata_i;
          RG_SB_CTRL: thr_q    <= reg_wdata_i[THR_LSB +: THR_W];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RG_DETECT:   reg_rdata_o = {30'd0, flags_q};
      RG_IRQ_EN:   reg_rdata_o = {30'd0, irq_en_q};
      RG_DISABLE:  reg_rdata_o = dis_q;
      RG_SB_CTRL:  reg_rdata_o[THR_LSB +: THR_W] = thr_q;
      RG_DATA_HI:  reg_rdata_o = cap_data[DATA_W-1:HALF_W];
      RG_DATA_LO:  reg_rdata_o = cap_data[HALF_W-1:0];
      RG_CHECK:    reg_rdata_o = REG_DW'(cap_chk);
      RG_ADDR_LO:  reg_rdata_o = cap_addr[31:0];
      RG_ADDR_EXT: reg_rdata_o = REG_DW'(cap_addr[ADDR_W-1:32]);
      default:     reg_rdata_o = '0;
    endcase
    if (reg_addr_i == RG_SB_CTRL) reg_rdata_o[THR_W-1:0] = cnt;
  end

  assign irq_o = |(flags_q & irq_en_q);

  p_mbe_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_ev |=> flags_q[FLAG_MB]);
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == RG_DETECT && reg_wdata_i[FLAG_MB] && !mb_ev)
    |=> !flags_q[FLAG_MB]);
  p_mask_mbe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_q[FLAG_MB] && !flags_q[FLAG_MB]) |=> !flags_q[FLAG_MB]);
  p_zero_thr_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == '0 && !flags_q[FLAG_SB]) |=> !flags_q[FLAG_SB]);
  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !reg_wr_i) |=> irq_o);
endmodule

// File: tb/mem_err_report_test.sv
`timescale 1ns/1ps
module mem_err_report_test;
  logic        clk_i = 0, rst_ni = 0;
  logic        sbe_i = 0, mbe_i = 0, narrow_bus_i = 0, reg_wr_i = 0;
  logic [39:0] err_addr_i = '0;
  logic [63:0] err_data_i = '0;
  logic [15:0] err_chk_i = '0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [1:0]  m_flags = 0, m_en = 0;
  logic [31:0] m_dis = 0;
  int          m_thr = 0, m_cnt = 0;
  logic [63:0] m_data = 0;
  logic [15:0] m_chk = 0;
  logic [39:0] m_addr = 0;

  mem_err_report uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_of(int a);
    case (a)
      0: return {30'd0, m_flags};
      1: return {30'd0, m_en};
      2: return m_dis;
      3: return {8'd0, 8'(m_thr), 8'd0, 8'(m_cnt)};
      4: return m_data[63:32];
      5: return m_data[31:0];
      6: return {16'd0, m_chk};
      7: return m_addr[31:0];
      8: return {24'd0, m_addr[39:32]};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2 detect";
      1: return "R11 enable";
      2: return "R10 disable";
      3: return "R3 counter";
      default: return "R7 capture";
    endcase
  endfunction

  task automatic compare_all();
    for (int a = 0; a < 10; a++) begin
      reg_addr_i = 4'(a);
      #0.2;
      check(a == 9 ? "R1 unused index" : tag_of(a), reg_rdata_o, a == 9 ? 0 : exp_of(a));
    end
    check("R11 irq", {31'd0, irq_o}, {31'd0, |(m_flags & m_en)});
  endtask

  task automatic rd(string tag, int a, logic [31:0] exp);
    reg_addr_i = 4'(a);
    #0.2;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic model_step(logic s, logic m, logic [39:0] a, logic [63:0] d,
                            logic [15:0] c, logic nar, logic w, int wa, logic [31:0] wd);
    logic sev, mev, hit;
    logic [1:0] clr;
    int cnt_n;
    sev = s && !m_dis[0];
    mev = m && !m_dis[1];
    hit = 0;
    cnt_n = m_cnt;
    if (m_thr == 0) cnt_n = 0;
    else if (sev) begin
      if (m_cnt + 1 >= m_thr) begin hit = 1; cnt_n = 0; end
      else cnt_n = m_cnt + 1;
    end
    if ((sev || mev) && m_flags == 0) begin
      m_data = d; m_addr = a; m_chk = nar ? c : {8'd0, c[7:0]};
    end
    clr = (w && wa == 0) ? wd[1:0] : 2'b00;
    m_flags = (m_flags & ~clr) | {mev, hit};
    m_cnt = cnt_n;
    if (w && wa == 1) m_en = wd[1:0];
    if (w && wa == 2) m_dis = wd;
    if (w && wa == 3) m_thr = int'(wd[23:16]);
  endtask

  task automatic cyc(logic s, logic m, logic [39:0] a, logic [63:0] d, logic [15:0] c,
                     logic nar, logic w, int wa, logic [31:0] wd);
    sbe_i = s; mbe_i = m; err_addr_i = a; err_data_i = d; err_chk_i = c;
    narrow_bus_i = nar; reg_wr_i = w; reg_addr_i = 4'(wa); reg_wdata_i = wd;
    @(posedge clk_i);
    model_step(s, m, a, d, c, nar, w, wa, wd);
    @(negedge clk_i);
    sbe_i = 0; mbe_i = 0; reg_wr_i = 0;
    compare_all();
  endtask

  task automatic wr(int wa, logic [31:0] wd);
    cyc(0, 0, '0, '0, '0, 0, 1, wa, wd);
  endtask

  task automatic sb(logic [63:0] d, logic [15:0] c, logic nar);
    cyc(1, 0, 40'h12_0000_0040, d, c, nar, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    compare_all();
    rd("R1 detect after reset", 0, 0);
    check("R1 irq after reset", {31'd0, irq_o}, 0);

    // multi-bit event, capture, freeze, clear
    wr(1, 32'h3);
    cyc(0, 1, 40'hAB_1234_5678, 64'hDEAD_BEEF_0123_4567, 16'h12C3, 0, 0, 0, 0);
    rd("R2 mbe flag", 0, 32'h2);
    check("R11 irq on mbe", {31'd0, irq_o}, 1);
    rd("R9 wide check masked", 6, 32'h0000_00C3);
    rd("R7 address ext", 8, 32'hAB);
    cyc(0, 1, 40'h01_0000_0000, 64'h1111_2222_3333_4444, 16'hFFFF, 1, 0, 0, 0);
    rd("R8 frozen data lo", 5, 32'h0123_4567);
    wr(0, 32'h0);
    rd("R6 write zero keeps", 0, 32'h2);
    wr(0, 32'h2);
    rd("R6 write one clears", 0, 32'h0);
    check("R11 irq drops", {31'd0, irq_o}, 0);

    // threshold 3
    wr(3, 32'h0003_0000);
    sb(64'hA, 16'h1, 0);
    sb(64'hB, 16'h2, 0);
    rd("R3 count two", 3, 32'h0003_0002);
    rd("R3 no flag yet", 0, 32'h0);
    sb(64'hC, 16'h3, 0);
    rd("R3 flag at threshold", 0, 32'h1);
    rd("R3 count wraps", 3, 32'h0003_0000);
    wr(0, 32'h3);

    // threshold 1
    wr(3, 32'h0001_0000);
    sb(64'hD, 16'h4, 0);
    rd("R4 first sbe flags", 0, 32'h1);
    wr(0, 32'h1);
    sb(64'hE, 16'h5, 0);
    rd("R4 second sbe flags", 0, 32'h1);
    // set beats same-cycle clear
    cyc(1, 0, 40'h5, 64'hF, 16'h6, 0, 1, 0, 32'h1);
    rd("R6 set wins over clear", 0, 32'h1);
    wr(0, 32'h3);

    // narrow bus capture
    sb(64'h0, 16'hBEEF, 1);
    rd("R9 narrow check kept", 6, 32'h0000_BEEF);
    wr(0, 32'h3);

    // threshold 0
    wr(3, 32'h0);
    sb(64'h1, 16'h1, 0);
    sb(64'h2, 16'h1, 0);
    sb(64'h3, 16'h1, 0);
    rd("R5 no flag", 0, 32'h0);
    rd("R5 counter idle", 3, 32'h0);

    // disable masks
    wr(2, 32'hA5A5_0003);
    rd("R10 full readback", 2, 32'hA5A5_0003);
    wr(3, 32'h0001_0000);
    sb(64'h77, 16'h7, 0);
    cyc(0, 1, 40'h9, 64'h88, 16'h8, 0, 0, 0, 0);
    rd("R10 masked no flag", 0, 32'h0);
    rd("R10 masked no capture", 5, 32'h3);
    wr(2, 32'h0);
    cyc(0, 1, 40'h9, 64'h88, 16'h8, 0, 0, 0, 0);
    rd("R10 unmasked flags", 0, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule